// File: doc/BRIEF.md
# Symbol Timing and Manchester Integrity Checker

This block judges the quality of a received hard-symbol stream at the start of a telegram. It takes half-symbol decisions (chips) from the data slicer together with edge events from a recovered symbol clock. Each edge event carries its phase error. The block raises sticky failure flags when an edge falls outside a programmable window or when the chip stream breaks Manchester coding. A strict start mode can also be enabled, in which the opening symbols of a telegram must alternate.

A programmable check size sets how many complete symbols must arrive before the block declares success. When that many symbols have been seen and a check has not failed, its OK flag is set. The timing and Manchester OK flags are combined with two externally produced OK flags, one for carrier and one for modulation amplitude. The result is a single start-of-telegram valid indication. A telegram-start pulse restarts everything. Clock recovery itself is not part of the block: it only consumes the edge phase that clock recovery reports.

Top module: `sym_integrity_chk`

## Requirements
- R1: An edge strobe whose phase, a two's-complement offset in 1/16-symbol units, has a magnitude greater than the timing limit sets the timing failure flag on the following cycle. A magnitude equal to or below the limit does not set it.
- R2: The timing and Manchester failure flags remain set once raised, until telegram start or reset.
- R3: Chips are paired into symbols. The first chip is the symbol value, so chips 1,0 form symbol 1 and chips 0,1 form symbol 0. A pair of equal chips sets the Manchester failure flag on the cycle after the second chip.
- R4: The first chip accepted after telegram start is always the first half of a symbol, whatever half was pending before.
- R5: With strict mode on, a symbol that equals its predecessor sets the Manchester failure flag when the symbol is one of the first check-size symbols of the telegram.
- R6: Strict mode has no effect on the symbols that follow the first check-size symbols. With strict mode off, repeated symbols are accepted.
- R7: A check's OK flag sets on the cycle after the symbol that brings the symbol count to the check size, provided that check's failure flag is clear. A check size of 0 acts as 1. The flag stays set.
- R8: A failure that arrives before or together with the qualifying symbol keeps that check's OK flag clear for the rest of the telegram. A failure that arrives after qualification leaves the OK flag set.
- R9: The start-of-telegram valid output is high exactly when the carrier OK input, the amplitude OK input and both internal OK flags are all high.
- R10: Reset and telegram start clear all flags and the symbol count. Chip and edge strobes in the telegram-start cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tlg_start_i | input | 1 | Telegram start pulse, restarts all checks |
| chip_stb_i | input | 1 | Half-symbol decision strobe |
| chip_i | input | 1 | Half-symbol value |
| edge_stb_i | input | 1 | Data edge event from clock recovery |
| edge_phase_i | input | PH_W | Signed edge phase error, 1/16-symbol units |
| time_lim_i | input | PH_W | Allowed edge phase magnitude |
| chk_size_i | input | CNT_W | Symbols required before OK flags may set |
| strict_i | input | 1 | Strict alternating start mode enable |
| carrier_ok_i | input | 1 | External carrier check OK |
| ampl_ok_i | input | 1 | External modulation amplitude OK |
| tim_fail_o | output | 1 | Symbol timing failure (sticky) |
| tim_ok_o | output | 1 | Symbol timing OK |
| man_fail_o | output | 1 | Manchester failure (sticky) |
| man_ok_o | output | 1 | Manchester OK |
| sot_valid_o | output | 1 | Start-of-telegram valid |

## Verification
The bench sweeps every edge phase against a range of timing limits. The equal-to-limit and most-negative phase cases expose an off-by-one or an absolute-value overflow: such a design would flag a legal edge, or pass an edge that is too wide. It sweeps the check size against the number of clean symbols sent, which catches an OK flag that sets one symbol early or late. It also sends repeated symbols just inside and just outside the strict window, which catches a window boundary in the wrong place. Further cases put a failure in the same cycle as the qualifying symbol and leave a stray chip pending across a telegram start. A design that ignored the same-cycle failure, or kept the stale half-symbol phase, would report OK or a spurious Manchester failure.

// File: rtl/sic_pkg.sv
package sic_pkg;

    // Which half of a Manchester symbol the next chip belongs to
    typedef enum logic {
        HALF_A = 1'b0,
        HALF_B = 1'b1
    } half_e;

    // Index of each internally judged check
    localparam int CHK_TIM = 0;
    localparam int CHK_MAN = 1;
    localparam int N_CHK   = 2;

    // Event and state of one check
    typedef struct packed {
        logic hit;   // violation detected this cycle
        logic fail;  // sticky failure
    } chk_evt_t;

    // Next value of a sticky qualified OK flag
    function automatic logic ok_next(logic ok_q, logic qual, chk_evt_t e);
        return ok_q | (qual & ~e.fail & ~e.hit);
    endfunction

endpackage

// File: rtl/sic_edge_timing.sv
module sic_edge_timing #(
    parameter int PH_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   edge_stb,
    input  logic signed [PH_W-1:0] phase,
    input  logic        [PH_W-1:0] lim,
    output sic_pkg::chk_evt_t      evt
);
    logic [PH_W-1:0] mag;
    logic            fail_q;

    // Magnitude of the phase error; the most negative code maps to 2**(PH_W-1)
    always_comb begin
        if (phase[PH_W-1]) mag = ~phase + 1'b1;
        else               mag = phase;
    end

    always_comb begin
        evt.hit  = edge_stb & ~clr & (mag > lim);
        evt.fail = fail_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) fail_q <= 1'b0;
        else            fail_q <= fail_q | evt.hit;
    end
endmodule

// File: rtl/sic_manch_chk.sv
module sic_manch_chk (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              chip_stb,
    input  logic              chip,
    input  logic              strict,
    input  logic              strict_win,
    output logic              sym_done,
    output sic_pkg::chk_evt_t evt
);
    import sic_pkg::*;

    half_e half_q;
    logic  first_q;
    logic  prev_q;
    logic  have_prev_q;
    logic  fail_q;
    logic  pair_bad;
    logic  alt_bad;

    always_comb begin
        sym_done = chip_stb & ~clr & (half_q == HALF_B);
        pair_bad = sym_done & (chip == first_q);
        alt_bad  = sym_done & strict & strict_win & have_prev_q & (first_q == prev_q);
        evt.hit  = pair_bad | alt_bad;
        evt.fail = fail_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            half_q      <= HALF_A;
            first_q     <= 1'b0;
            prev_q      <= 1'b0;
            have_prev_q <= 1'b0;
            fail_q      <= 1'b0;
        end else begin
            fail_q <= fail_q | evt.hit;
            if (chip_stb) begin
                if (half_q == HALF_A) begin
                    first_q <= chip;
                    half_q  <= HALF_B;
                end else begin
                    prev_q      <= first_q;
                    have_prev_q <= 1'b1;
                    half_q      <= HALF_A;
                end
            end
        end
    end
endmodule

// File: rtl/sic_sym_qual.sv
module sic_sym_qual #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             sym_done,
    input  logic [CNT_W-1:0] chk_size,
    output logic             strict_win,
    output logic             qual
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   idx;   // 1-based index of the symbol now completing

    always_comb begin
        idx        = {1'b0, cnt_q} + 1'b1;
        strict_win = idx <= {1'b0, chk_size};
        qual       = sym_done & (idx >= {1'b0, chk_size});
    end

    always_ff @(posedge clk) begin
        if (rst || clr)                     cnt_q <= '0;
        else if (sym_done && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sym_integrity_chk.sv
module sym_integrity_chk #(
    parameter int PH_W  = 6,
    parameter int CNT_W = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tlg_start_i,
    input  logic                   chip_stb_i,
    input  logic                   chip_i,
    input  logic                   edge_stb_i,
    input  logic signed [PH_W-1:0] edge_phase_i,
    input  logic        [PH_W-1:0] time_lim_i,
    input  logic       [CNT_W-1:0] chk_size_i,
    input  logic                   strict_i,
    input  logic                   carrier_ok_i,
    input  logic                   ampl_ok_i,
    output logic                   tim_fail_o,
    output logic                   tim_ok_o,
    output logic                   man_fail_o,
    output logic                   man_ok_o,
    output logic                   sot_valid_o
);
    import sic_pkg::*;

    chk_evt_t         evt [N_CHK];
    logic [N_CHK-1:0] ok_q;
    logic             sym_done;
    logic             strict_win;
    logic             qual;

    sic_edge_timing #(.PH_W(PH_W)) u_timing (
        .clk      (clk),
        .rst      (rst),
        .clr      (tlg_start_i),
        .edge_stb (edge_stb_i),
        .phase    (edge_phase_i),
        .lim      (time_lim_i),
        .evt      (evt[CHK_TIM])
    );

    sic_manch_chk u_manch (
        .clk        (clk),
        .rst        (rst),
        .clr        (tlg_start_i),
        .chip_stb   (chip_stb_i),
        .chip       (chip_i),
        .strict     (strict_i),
        .strict_win (strict_win),
        .sym_done   (sym_done),
        .evt        (evt[CHK_MAN])
    );

    sic_sym_qual #(.CNT_W(CNT_W)) u_qual (
        .clk        (clk),
        .rst        (rst),
        .clr        (tlg_start_i),
        .sym_done   (sym_done),
        .chk_size   (chk_size_i),
        .strict_win (strict_win),
        .qual       (qual)
    );

    for (genvar g = 0; g < N_CHK; g++) begin : g_ok
        always_ff @(posedge clk) begin
            if (rst || tlg_start_i) ok_q[g] <= 1'b0;
            else                    ok_q[g] <= ok_next(ok_q[g], qual, evt[g]);
        end
    end

    always_comb begin
        tim_fail_o  = evt[CHK_TIM].fail;
        man_fail_o  = evt[CHK_MAN].fail;
        tim_ok_o    = ok_q[CHK_TIM];
        man_ok_o    = ok_q[CHK_MAN];
        sot_valid_o = carrier_ok_i & ampl_ok_i & ok_q[CHK_TIM] & ok_q[CHK_MAN];
    end
endmodule

// File: rtl/sic_chk_props.sv
module sic_chk_props #(
    parameter int PH_W  = 6,
    parameter int CNT_W = 5
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   tlg_start_i,
    input logic                   chip_stb_i,
    input logic                   edge_stb_i,
    input logic signed [PH_W-1:0] edge_phase_i,
    input logic        [PH_W-1:0] time_lim_i,
    input logic                   carrier_ok_i,
    input logic                   ampl_ok_i,
    input logic                   tim_fail_o,
    input logic                   tim_ok_o,
    input logic                   man_fail_o,
    input logic                   man_ok_o,
    input logic                   sot_valid_o
);
    int  ph_i;
    int  lim_i;
    logic wide;

    always_comb begin
        ph_i  = int'(edge_phase_i);
        lim_i = int'({1'b0, time_lim_i});
        wide  = (ph_i > lim_i) || (ph_i < -lim_i);
    end

    a_r1_wide_edge_fails: assert property (@(posedge clk) disable iff (rst)
        (edge_stb_i && !tlg_start_i && wide) |=> tim_fail_o);

    a_r2_tim_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (tim_fail_o && !tlg_start_i) |=> tim_fail_o);

    a_r2_man_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (man_fail_o && !tlg_start_i) |=> man_fail_o);

    a_r3_man_fail_on_chip: assert property (@(posedge clk) disable iff (rst)
        $rose(man_fail_o) |-> $past(chip_stb_i));

    a_r7_ok_on_chip: assert property (@(posedge clk) disable iff (rst)
        $rose(man_ok_o) |-> $past(chip_stb_i));

    a_r8_tim_ok_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(tim_ok_o) |-> !tim_fail_o);

    a_r8_man_ok_clean: assert property (@(posedge clk) disable iff (rst)
        $rose(man_ok_o) |-> !man_fail_o);

    a_r9_sot_needs_all: assert property (@(posedge clk) disable iff (rst)
        sot_valid_o |-> (carrier_ok_i && ampl_ok_i && tim_ok_o && man_ok_o));

    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        tlg_start_i |=> (!tim_fail_o && !man_fail_o && !tim_ok_o && !man_ok_o));
endmodule

bind sym_integrity_chk sic_chk_props #(.PH_W(PH_W), .CNT_W(CNT_W)) u_props (
    .clk          (clk),
    .rst          (rst),
    .tlg_start_i  (tlg_start_i),
    .chip_stb_i   (chip_stb_i),
    .edge_stb_i   (edge_stb_i),
    .edge_phase_i (edge_phase_i),
    .time_lim_i   (time_lim_i),
    .carrier_ok_i (carrier_ok_i),
    .ampl_ok_i    (ampl_ok_i),
    .tim_fail_o   (tim_fail_o),
    .tim_ok_o     (tim_ok_o),
    .man_fail_o   (man_fail_o),
    .man_ok_o     (man_ok_o),
    .sot_valid_o  (sot_valid_o)
);

// File: tb/sym_integrity_chk_bench.sv
module sym_integrity_chk_bench;
    localparam int PH_W  = 6;
    localparam int CNT_W = 5;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   tlg_start;
    logic                   chip_stb;
    logic                   chip;
    logic                   edge_stb;
    logic signed [PH_W-1:0] edge_phase;
    logic        [PH_W-1:0] time_lim;
    logic       [CNT_W-1:0] chk_size;
    logic                   strict;
    logic                   carrier_ok;
    logic                   ampl_ok;
    logic                   tim_fail, tim_ok, man_fail, man_ok, sot_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    sym_integrity_chk #(.PH_W(PH_W), .CNT_W(CNT_W)) u_sym_integrity_chk (
        .clk          (clk),
        .rst          (rst),
        .tlg_start_i  (tlg_start),
        .chip_stb_i   (chip_stb),
        .chip_i       (chip),
        .edge_stb_i   (edge_stb),
        .edge_phase_i (edge_phase),
        .time_lim_i   (time_lim),
        .chk_size_i   (chk_size),
        .strict_i     (strict),
        .carrier_ok_i (carrier_ok),
        .ampl_ok_i    (ampl_ok),
        .tim_fail_o   (tim_fail),
        .tim_ok_o     (tim_ok),
        .man_fail_o   (man_fail),
        .man_ok_o     (man_ok),
        .sot_valid_o  (sot_valid)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic telegram();
        tlg_start = 1'b1;
        tick();
        tlg_start = 1'b0;
    endtask

    task automatic send_chip(logic v);
        chip_stb = 1'b1;
        chip     = v;
        tick();
        chip_stb = 1'b0;
    endtask

    task automatic send_sym(logic v);
        send_chip(v);
        send_chip(~v);
    endtask

    task automatic send_edge(int ph);
        edge_stb   = 1'b1;
        edge_phase = PH_W'(ph);
        tick();
        edge_stb   = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; tlg_start = 1'b0; chip_stb = 1'b0; chip = 1'b0;
        edge_stb = 1'b0; edge_phase = '0; time_lim = '0; chk_size = 5'd2;
        strict = 1'b0; carrier_ok = 1'b1; ampl_ok = 1'b1;
        #1;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10: reset state
        check("R10 reset tim_fail", tim_fail, 1'b0);
        check("R10 reset man_fail", man_fail, 1'b0);
        check("R10 reset tim_ok", tim_ok, 1'b0);
        check("R10 reset man_ok", man_ok, 1'b0);
        check("R9 reset sot_valid", sot_valid, 1'b0);

        // R1: phase against limit sweep
        for (int lim = 0; lim <= 10; lim++) begin
            for (int ph = -16; ph <= 15; ph++) begin
                time_lim = PH_W'(lim);
                telegram();
                send_edge(ph);
                check("R1 edge window", tim_fail, ((ph < 0 ? -ph : ph) > lim));
            end
        end
        // R1: most negative phase against the largest limit below its magnitude
        time_lim = PH_W'(31);
        telegram();
        send_edge(-32);
        check("R1 most negative phase", tim_fail, 1'b1);
        telegram();
        send_edge(31);
        check("R1 edge at limit", tim_fail, 1'b0);

        // R2: sticky timing failure
        time_lim = PH_W'(4);
        telegram();
        send_edge(9);
        repeat (5) tick();
        send_edge(1);
        check("R2 tim_fail sticky", tim_fail, 1'b1);

        // R3: all chip pairs, strict off
        strict = 1'b0;
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                telegram();
                send_chip(a[0]);
                check("R3 first half no fail", man_fail, 1'b0);
                send_chip(b[0]);
                check("R3 pair", man_fail, (a == b));
                repeat (3) tick();
                check("R2 man_fail sticky", man_fail, (a == b));
            end
        end

        // R4: stale half chip across telegram start
        telegram();
        send_chip(1'b1);
        telegram();
        send_sym(1'b1);
        check("R4 pairing restarts", man_fail, 1'b0);

        // R5: repeat inside strict window
        chk_size = 5'd4; strict = 1'b1;
        telegram();
        send_sym(1'b1);
        send_sym(1'b0);
        check("R5 alternating ok", man_fail, 1'b0);
        send_sym(1'b0);
        check("R5 repeat in window", man_fail, 1'b1);
        // R5: repeat at the last symbol of the window
        telegram();
        send_sym(1'b1); send_sym(1'b0); send_sym(1'b1); send_sym(1'b1);
        check("R5 repeat at window end", man_fail, 1'b1);

        // R6: repeat just after the window
        chk_size = 5'd2;
        telegram();
        send_sym(1'b1); send_sym(1'b0); send_sym(1'b0);
        check("R6 repeat after window", man_fail, 1'b0);
        check("R6 man_ok kept", man_ok, 1'b1);
        // R6: strict off accepts repeats
        strict = 1'b0; chk_size = 5'd4;
        telegram();
        send_sym(1'b1); send_sym(1'b1);
        check("R6 strict off", man_fail, 1'b0);

        // R7: check size against symbol count
        strict = 1'b1;
        for (int cs = 0; cs <= 6; cs++) begin
            chk_size = CNT_W'(cs);
            telegram();
            for (int k = 1; k <= 8; k++) begin
                send_chip(k[0]);
                check("R7 no ok mid symbol", man_ok, (k - 1 >= (cs < 1 ? 1 : cs)));
                send_chip(~k[0]);
                check("R7 tim_ok count", tim_ok, (k >= (cs < 1 ? 1 : cs)));
                check("R7 man_ok count", man_ok, (k >= (cs < 1 ? 1 : cs)));
            end
        end

        // R8: failure before qualification
        chk_size = 5'd3; time_lim = PH_W'(2);
        telegram();
        send_sym(1'b1);
        send_edge(5);
        send_sym(1'b0); send_sym(1'b1); send_sym(1'b0);
        check("R8 early fail blocks tim_ok", tim_ok, 1'b0);
        check("R8 man_ok unaffected", man_ok, 1'b1);
        // R8: failure in the qualifying cycle
        telegram();
        send_sym(1'b1); send_sym(1'b0);
        send_chip(1'b1);
        chip_stb = 1'b1; chip = 1'b0; edge_stb = 1'b1; edge_phase = PH_W'(-7);
        tick();
        chip_stb = 1'b0; edge_stb = 1'b0;
        check("R8 same cycle fail", tim_ok, 1'b0);
        check("R8 same cycle fail flag", tim_fail, 1'b1);
        // R8: failure after qualification
        chk_size = 5'd2;
        telegram();
        send_sym(1'b1); send_sym(1'b0);
        send_edge(6);
        check("R8 late fail flag", tim_fail, 1'b1);
        check("R8 late fail keeps ok", tim_ok, 1'b1);

        // R9: combination with external OK inputs
        telegram();
        send_sym(1'b1); send_sym(1'b0);
        for (int c = 0; c < 4; c++) begin
            carrier_ok = c[0]; ampl_ok = c[1];
            #1;
            check("R9 sot combine", sot_valid, (c == 3));
        end
        telegram();
        check("R9 sot cleared", sot_valid, 1'b0);

        // R10: strobes during telegram start are ignored
        tlg_start = 1'b1; chip_stb = 1'b1; chip = 1'b1;
        edge_stb = 1'b1; edge_phase = PH_W'(20);
        tick();
        tlg_start = 1'b0; chip_stb = 1'b0; edge_stb = 1'b0;
        check("R10 edge ignored at start", tim_fail, 1'b0);
        send_sym(1'b0);
        check("R10 chip ignored at start", man_fail, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule